// File: doc/BRIEF.md
# Spike-Timing Plastic Synapse

This block keeps one 8-bit synaptic weight and changes it according to the relative timing of two spike inputs. One input carries the spikes of the neuron that drives the synapse (pre), the other carries the spikes of the neuron it feeds (post). Two small saturating age counters record how many cycles have passed since the most recent spike on each input.

When a post spike lands shortly after a pre spike, the weight grows by a fixed step of 20. When a pre spike lands shortly after a post spike, it shrinks by a fixed step of 10. "Shortly" means within 10 clock cycles. The result is held between 0 and 255. The weight is a registered output. A neuron model reads it to scale the current it passes downstream.

Top module: `stdp_synapse`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the weight reads 100. Both age counters reset to their saturated value of 15, so that no window is open when reset ends.
- R2: A post spike without a pre spike in the same cycle, arriving 1 to 10 cycles after the most recent pre spike, adds 20 to the weight. The new value is visible on the output after the clock edge that samples the spike.
- R3: A pre spike without a post spike in the same cycle, arriving 1 to 10 cycles after the most recent post spike, subtracts 10 from the weight. It is visible after the same edge.
- R4: A spike that arrives 11 or more cycles after the most recent spike on the other input leaves the weight unchanged.
- R5: A potentiation that would go above 255 sets the weight to 255.
- R6: A depression that would go below 0 sets the weight to 0.
- R7: Pre and post spikes in the same cycle leave the weight unchanged, and both windows restart from that cycle.
- R8: A cycle with no spike, or with repeated spikes on only one input and no open window from the other, leaves the weight unchanged.
- R9: A post spike does not close the pre window. Each post spike that lands within 10 cycles of one pre spike potentiates again.
- R10: The weight changes at most once per cycle, and only by +20, by -10, or to a clamp limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pre_spike | input | 1 | Spike from the driving neuron, one cycle per spike |
| post_spike | input | 1 | Spike from the driven neuron, one cycle per spike |
| weight | output | 8 | Current synaptic weight |

## Verification
The bench probes both edges of the window: a separation of 10 cycles must still update the weight, and a separation of 11 must not. An off-by-one in counter start or comparison would move either result. It drives the weight into both rails, starting from values that are not multiples of the step. A wrapping adder would show a small value instead of 255, and an unguarded subtractor would show a value near 250 instead of 0. It also sends coincident spikes, which a design without a tie rule would turn into a spurious update. It sends a lone spike right after reset, which counters cleared to zero would treat as being inside an open window. Finally, it sends two post spikes after one pre spike, which a design that clears the pre counter on post would count only once.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    localparam int unsigned WEIGHT_W_DEF = 8;
    localparam int unsigned AGE_W_DEF    = 4;
    localparam int unsigned WINDOW_DEF   = 10;
    localparam int unsigned INIT_W_DEF   = 100;
    localparam int unsigned POT_DEF      = 20;
    localparam int unsigned DEP_DEF      = 10;

    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_POT  = 2'd1,
        UPD_DEP  = 2'd2
    } upd_e;

    typedef struct packed {
        logic pre;
        logic post;
    } spike_pair_t;

    // Window is open while fewer than win cycles have elapsed.
    function automatic logic age_open(input int unsigned age, input int unsigned win);
        return age < win;
    endfunction

endpackage

// File: rtl/spike_age_counter.sv
module spike_age_counter #(
    parameter int unsigned AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spike,
    output logic [AGE_W-1:0] age
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= AGE_MAX;
        end else if (spike) begin
            age <= '0;
        end else if (age != AGE_MAX) begin
            age <= age + 1'b1;
        end
    end
endmodule

// File: rtl/stdp_rule.sv
module stdp_rule
    import stdp_pkg::*;
#(
    parameter int unsigned AGE_W  = 4,
    parameter int unsigned WINDOW = 10
) (
    input  spike_pair_t      spk,
    input  logic [AGE_W-1:0] pre_age,
    input  logic [AGE_W-1:0] post_age,
    output upd_e             upd
);
    always_comb begin
        upd = UPD_HOLD;
        if (spk.post && !spk.pre && age_open(int'(pre_age), WINDOW)) begin
            upd = UPD_POT;
        end else if (spk.pre && !spk.post && age_open(int'(post_age), WINDOW)) begin
            upd = UPD_DEP;
        end
    end
endmodule

// File: rtl/weight_reg.sv
module weight_reg
    import stdp_pkg::*;
#(
    parameter int unsigned WEIGHT_W = 8,
    parameter int unsigned INIT_W   = 100,
    parameter int unsigned POT_STEP = 20,
    parameter int unsigned DEP_STEP = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  upd_e                upd,
    output logic [WEIGHT_W-1:0] weight
);
    localparam int unsigned      EXT_W = WEIGHT_W + 2;
    localparam logic [EXT_W-1:0] W_MAX = EXT_W'((1 << WEIGHT_W) - 1);
    localparam logic [EXT_W-1:0] POT_E = EXT_W'(POT_STEP);
    localparam logic [EXT_W-1:0] DEP_E = EXT_W'(DEP_STEP);

    logic [EXT_W-1:0]    w_ext;
    logic [EXT_W-1:0]    sum_ext;
    logic [WEIGHT_W-1:0] w_next;

    assign w_ext   = {2'b00, weight};
    assign sum_ext = w_ext + POT_E;

    always_comb begin
        w_next = weight;
        unique case (upd)
            UPD_POT: w_next = (sum_ext > W_MAX) ? W_MAX[WEIGHT_W-1:0]
                                                : sum_ext[WEIGHT_W-1:0];
            UPD_DEP: w_next = (w_ext < DEP_E) ? '0
                                              : WEIGHT_W'(w_ext - DEP_E);
            default: w_next = weight;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            weight <= WEIGHT_W'(INIT_W);
        end else begin
            weight <= w_next;
        end
    end
endmodule

// File: rtl/stdp_synapse.sv
module stdp_synapse
    import stdp_pkg::*;
#(
    parameter int unsigned WEIGHT_W = WEIGHT_W_DEF,
    parameter int unsigned AGE_W    = AGE_W_DEF,
    parameter int unsigned WINDOW   = WINDOW_DEF,
    parameter int unsigned INIT_W   = INIT_W_DEF,
    parameter int unsigned POT_STEP = POT_DEF,
    parameter int unsigned DEP_STEP = DEP_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pre_spike,
    input  logic                post_spike,
    output logic [WEIGHT_W-1:0] weight
);
    localparam int unsigned N_SIDES = 2;  // index 0: pre, 1: post

    logic [N_SIDES-1:0] spk_vec;
    logic [AGE_W-1:0]   age_arr [N_SIDES];
    logic [AGE_W-1:0]   pre_age;
    logic [AGE_W-1:0]   post_age;
    spike_pair_t        spk;
    upd_e               upd;

    assign spk_vec  = {post_spike, pre_spike};
    assign spk.pre  = pre_spike;
    assign spk.post = post_spike;

    for (genvar i = 0; i < N_SIDES; i++) begin : g_age
        spike_age_counter #(.AGE_W(AGE_W)) u_age (
            .clk  (clk),
            .rst  (rst),
            .spike(spk_vec[i]),
            .age  (age_arr[i])
        );
    end

    assign pre_age  = age_arr[0];
    assign post_age = age_arr[1];

    stdp_rule #(.AGE_W(AGE_W), .WINDOW(WINDOW)) u_rule (
        .spk     (spk),
        .pre_age (pre_age),
        .post_age(post_age),
        .upd     (upd)
    );

    weight_reg #(
        .WEIGHT_W(WEIGHT_W),
        .INIT_W  (INIT_W),
        .POT_STEP(POT_STEP),
        .DEP_STEP(DEP_STEP)
    ) u_wreg (
        .clk   (clk),
        .rst   (rst),
        .upd   (upd),
        .weight(weight)
    );
endmodule

// File: rtl/stdp_synapse_chk.sv
module stdp_synapse_chk #(
    parameter int unsigned WEIGHT_W = 8,
    parameter int unsigned AGE_W    = 4,
    parameter int unsigned WINDOW   = 10,
    parameter int unsigned INIT_W   = 100,
    parameter int unsigned POT_STEP = 20,
    parameter int unsigned DEP_STEP = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                pre_spike,
    input logic                post_spike,
    input logic [WEIGHT_W-1:0] weight,
    input logic [AGE_W-1:0]    pre_age,
    input logic [AGE_W-1:0]    post_age
);
    localparam int W_MAX   = (1 << WEIGHT_W) - 1;
    localparam int AGE_MAX = (1 << AGE_W) - 1;

    // R1
    reset_weight_chk: assert property (@(posedge clk)
        $past(rst) |-> int'(weight) == int'(INIT_W));

    // R1
    reset_age_chk: assert property (@(posedge clk)
        $past(rst) |-> (int'(pre_age) == AGE_MAX && int'(post_age) == AGE_MAX));

    // R2
    pot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (post_spike && !pre_spike && int'(pre_age) < int'(WINDOW)
         && int'(weight) <= W_MAX - int'(POT_STEP))
        |=> int'(weight) == int'($past(weight)) + int'(POT_STEP));

    // R3
    dep_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_spike && !post_spike && int'(post_age) < int'(WINDOW)
         && int'(weight) >= int'(DEP_STEP))
        |=> int'(weight) == int'($past(weight)) - int'(DEP_STEP));

    // R4
    late_post_chk: assert property (@(posedge clk) disable iff (rst)
        (post_spike && !pre_spike && int'(pre_age) >= int'(WINDOW)) |=> $stable(weight));

    // R4
    late_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_spike && !post_spike && int'(post_age) >= int'(WINDOW)) |=> $stable(weight));

    // R5
    clamp_high_chk: assert property (@(posedge clk) disable iff (rst)
        (post_spike && !pre_spike && int'(pre_age) < int'(WINDOW)
         && int'(weight) > W_MAX - int'(POT_STEP))
        |=> int'(weight) == W_MAX);

    // R6
    clamp_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_spike && !post_spike && int'(post_age) < int'(WINDOW)
         && int'(weight) < int'(DEP_STEP))
        |=> weight == '0);

    // R7
    tie_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_spike && post_spike) |=> ($stable(weight) && pre_age == '0 && post_age == '0));

    // R8
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pre_spike && !post_spike) |=> $stable(weight));

    // R10
    step_legal_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(weight) |->
            (int'(weight) == int'($past(weight)) + int'(POT_STEP)
             || int'(weight) == int'($past(weight)) - int'(DEP_STEP)
             || int'(weight) == W_MAX || weight == '0));
endmodule

bind stdp_synapse stdp_synapse_chk #(
    .WEIGHT_W(WEIGHT_W),
    .AGE_W   (AGE_W),
    .WINDOW  (WINDOW),
    .INIT_W  (INIT_W),
    .POT_STEP(POT_STEP),
    .DEP_STEP(DEP_STEP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pre_spike (pre_spike),
    .post_spike(post_spike),
    .weight    (weight),
    .pre_age   (pre_age),
    .post_age  (post_age)
);

// File: tb/stdp_synapse_tb.sv
module stdp_synapse_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_spike = 1'b0;
    logic       post_spike = 1'b0;
    logic [7:0] weight;

    int checks = 0;
    int errors = 0;
    int exp_w  = 100;

    always #2 clk = ~clk;  // 250 MHz

    stdp_synapse u_dut (
        .clk       (clk),
        .rst       (rst),
        .pre_spike (pre_spike),
        .post_spike(post_spike),
        .weight    (weight)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Entered and left at a falling edge.
    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one cycle of spikes; on return the sampling edge has passed.
    task automatic spike(input logic p, input logic q);
        pre_spike  = p;
        post_spike = q;
        @(negedge clk);
        pre_spike  = 1'b0;
        post_spike = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 initial weight", int'(weight), 100);
        spike(1'b0, 1'b1);
        chk("R1 lone post after reset", int'(weight), 100);
        idle(15);
        spike(1'b1, 1'b0);
        chk("R1 lone pre after reset", int'(weight), 100);
        idle(15);
    endtask

    task automatic t_pot_dep();
        do_reset();
        spike(1'b1, 1'b0); idle(2); spike(1'b0, 1'b1);
        chk("R2 post 3 cycles after pre", int'(weight), 120);
        idle(15);
        spike(1'b0, 1'b1); idle(2); spike(1'b1, 1'b0);
        chk("R3 pre 3 cycles after post", int'(weight), 110);
        idle(15);
    endtask

    task automatic t_window_edges();
        do_reset();
        spike(1'b1, 1'b0); idle(9); spike(1'b0, 1'b1);
        chk("R2 post 10 cycles after pre", int'(weight), 120);
        idle(15);
        spike(1'b1, 1'b0); idle(10); spike(1'b0, 1'b1);
        chk("R4 post 11 cycles after pre", int'(weight), 120);
        idle(15);
        spike(1'b0, 1'b1); idle(9); spike(1'b1, 1'b0);
        chk("R3 pre 10 cycles after post", int'(weight), 110);
        idle(15);
        spike(1'b0, 1'b1); idle(10); spike(1'b1, 1'b0);
        chk("R4 pre 11 cycles after post", int'(weight), 110);
        idle(15);
    endtask

    task automatic t_tie();
        do_reset();
        spike(1'b1, 1'b1);
        chk("R7 coincident spikes", int'(weight), 100);
        idle(1);
        spike(1'b0, 1'b1);
        chk("R7 tie restarts pre window (post 2 later)", int'(weight), 120);
        idle(15);
    endtask

    task automatic t_quiet();
        do_reset();
        idle(20);
        chk("R8 no spikes", int'(weight), 100);
        spike(1'b1, 1'b0); idle(1); spike(1'b1, 1'b0); idle(1); spike(1'b1, 1'b0);
        chk("R8 repeated pre only", int'(weight), 100);
        idle(15);
    endtask

    task automatic t_double_post();
        do_reset();
        spike(1'b1, 1'b0); spike(1'b0, 1'b1);
        chk("R9 first post in window", int'(weight), 120);
        idle(2);
        spike(1'b0, 1'b1);
        chk("R9 second post in same window", int'(weight), 140);
        idle(15);
    endtask

    task automatic t_clamps();
        do_reset();
        exp_w = 100;
        for (int i = 0; i < 9; i++) begin
            spike(1'b1, 1'b0); spike(1'b0, 1'b1);
            exp_w = (exp_w + 20 > 255) ? 255 : exp_w + 20;
            idle(12);
            if (i == 6) chk("R10 seventh potentiation", int'(weight), 240);
        end
        chk("R5 clamp at 255", int'(weight), 255);
        chk("R5 model agrees", exp_w, 255);
        for (int i = 0; i < 27; i++) begin
            spike(1'b0, 1'b1); spike(1'b1, 1'b0);
            exp_w = (exp_w < 10) ? 0 : exp_w - 10;
            idle(12);
            if (i == 24) chk("R3 weight 5 after 25 depressions", int'(weight), 5);
        end
        chk("R6 clamp at 0", int'(weight), 0);
        chk("R6 model agrees", exp_w, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_pot_dep();
        t_window_edges();
        t_tie();
        t_quiet();
        t_double_post();
        t_clamps();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule